// File: doc/BRIEF.md
# Serial ADC Word Formatter

This block turns 10-bit parallel converter samples into a single-line serial stream, one bit per bit time, with a frame clock that marks word boundaries and a data clock for the receiver to capture with. The core clock runs at a fixed multiple of the bit rate (`TPB` cycles per bit, default 12). This allows the data clock to be placed at any multiple of 60 degrees from the bit transitions, starting from a default offset of 90 degrees.

At each word boundary the block captures the sample and all control inputs. The control inputs set the serial word length (8, 10, 12 or 14 bits), the bit order, the output polarity and the data-clock phase. A test input replaces the sample with a fixed alignment word. Settings captured at a boundary hold for that whole word, so a word is never split between two configurations.

Top module: `adc_serial_fmt`

## Requirements
- R1: While `rst` is high, `ser_o`, `fclk_o` and `dclk_o` are all 0. The first rising edge of `clk` with `rst` low starts a word.
- R2: Each serial bit is held on `ser_o` for exactly `TPB` clock cycles. Words follow each other with no gap, and a new word starts on the edge after the last bit time of the previous word.
- R3: `wlen_i` selects the word length, captured at word start: 2'b00 = 10 bits, 2'b01 = 8 bits, 2'b10 = 12 bits, 2'b11 = 14 bits. In 10-bit mode the sample bits are sent with bit 9 first.
- R4: In 12-bit and 14-bit modes, the 10 sample bits are followed by 2 or 4 zero bits respectively.
- R5: In 8-bit mode only sample bits 9 down to 2 are sent.
- R6: With `lsb_first_i` = 1, the sample bits go out in reverse order (bit 0 first, or bit 2 first in 8-bit mode). Any zero padding still comes last.
- R7: With `invert_i` = 1, every serial bit of the word, padding included, is inverted. This control is independent of the bit order.
- R8: `fclk_o` is high for the first floor(L/2) bit times of each L-bit word and low for the remaining bit times.
- R9: Within every bit time, with t the cycle index 0 to 11 and k = `dphase_i` mod 6, `dclk_o` is high when (t - (3 + 2k)) mod 12 < 6. This places the data clock's rising edge at 90 + 60k degrees after the bit transition. Codes 6 and 7 act as 0 and 1.
- R10: With `test_word_i` = 1, the sample is replaced by 10'b10_0000_0000. Length, order and polarity still apply, and the frame and data clocks run as usual.
- R11: Sample and control inputs are used only as they stand on the edge that starts a word. Changes during a word have no effect on that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, TPB cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 10 | Parallel sample word |
| wlen_i | input | 2 | Serial word length code |
| lsb_first_i | input | 1 | Send least significant sample bit first |
| invert_i | input | 1 | Invert all serial bits |
| dphase_i | input | 3 | Data clock phase step code |
| test_word_i | input | 1 | Replace sample with the fixed alignment word |
| ser_o | output | 1 | Serial data line |
| fclk_o | output | 1 | Frame clock |
| dclk_o | output | 1 | Data clock |

## Verification
The bench builds the block with the default of 12 cycles per bit. At this setting every 60-degree phase step is exactly two cycles and the 90-degree default is three cycles, so all eight phase codes can be checked cycle by cycle against the data transitions. The inputs for the next word are changed on the cycle just after each word begins. Every word therefore also checks that settings are captured only at the boundary, across all four lengths, both bit orders, both polarities and the test word.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    localparam int SMP_W = 10;
    localparam int MAX_W = 14;
    localparam int PH_W  = 3;
    localparam int BC_W  = $clog2(MAX_W);

    localparam logic [SMP_W-1:0] ALIGN_WORD = 10'b10_0000_0000;

    typedef enum logic [1:0] {
        WL_10 = 2'b00,
        WL_8  = 2'b01,
        WL_12 = 2'b10,
        WL_14 = 2'b11
    } wlen_e;

    typedef struct packed {
        wlen_e            wlen;
        logic             lsb_first;
        logic             invert;
        logic [PH_W-1:0]  phase;
        logic             test;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{wlen: WL_10, lsb_first: 1'b0, invert: 1'b0,
                                   phase: '0, test: 1'b0};

    function automatic int word_bits(wlen_e w);
        case (w)
            WL_8:    return 8;
            WL_12:   return 12;
            WL_14:   return 14;
            default: return SMP_W;
        endcase
    endfunction

    // Word laid out in send order, first bit at the top of the vector.
    function automatic logic [MAX_W-1:0] pack_word(logic [SMP_W-1:0] smp, cfg_t c);
        logic [SMP_W-1:0] d;
        logic [MAX_W-1:0] r;
        int               len;
        int               nd;
        d   = c.test ? ALIGN_WORD : smp;
        len = word_bits(c.wlen);
        nd  = (c.wlen == WL_8) ? 8 : SMP_W;
        r   = '0;
        for (int i = 0; i < MAX_W; i++) begin
            logic b;
            b = 1'b0;
            if (i < nd)
                b = c.lsb_first ? d[SMP_W - nd + i] : d[SMP_W - 1 - i];
            if (i < len)
                b = b ^ c.invert;
            r[MAX_W - 1 - i] = b;
        end
        return r;
    endfunction

endpackage

// File: rtl/fmt_timing.sv
module fmt_timing
    import fmt_pkg::*;
#(
    parameter int TPB  = 12,
    localparam int TK_W = $clog2(TPB)
) (
    input  logic             clk,
    input  logic             rst,
    input  wlen_e            wlen,
    output logic [TK_W-1:0]  tick,
    output logic [BC_W-1:0]  bitc,
    output logic             frame_end
);

    logic [BC_W-1:0] last_bit;
    logic            bit_end;

    assign last_bit  = BC_W'(word_bits(wlen) - 1);
    assign bit_end   = (tick == TK_W'(TPB - 1));
    assign frame_end = bit_end && (bitc == last_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= TK_W'(TPB - 1);
            bitc <= BC_W'(SMP_W - 1);
        end else if (bit_end) begin
            tick <= '0;
            bitc <= frame_end ? '0 : bitc + 1'b1;
        end else begin
            tick <= tick + 1'b1;
        end
    end

endmodule

// File: rtl/fmt_shreg.sv
module fmt_shreg
    import fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [SMP_W-1:0]  smp,
    input  cfg_t              cfg_in,
    output cfg_t              cfg_q,
    output logic              ser
);

    logic [MAX_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            cfg_q <= CFG_RESET;
        end else if (load) begin
            sr    <= pack_word(smp, cfg_in);
            cfg_q <= cfg_in;
        end else if (shift) begin
            sr    <= sr << 1;
        end
    end

    assign ser = sr[MAX_W-1];

endmodule

// File: rtl/fmt_dclk.sv
module fmt_dclk
    import fmt_pkg::*;
#(
    parameter int TPB  = 12,
    localparam int TK_W = $clog2(TPB),
    localparam int BASE = TPB / 4,
    localparam int STEP = TPB / 6
) (
    input  logic [TK_W-1:0]  tick,
    input  logic [PH_W-1:0]  phase,
    output logic             dclk
);

    int k;
    int off;
    int rel;

    always_comb begin
        k   = (int'(phase) >= 6) ? int'(phase) - 6 : int'(phase);
        off = (BASE + k * STEP) % TPB;
        rel = (int'(tick) >= off) ? int'(tick) - off : int'(tick) + TPB - off;
        dclk = (rel < TPB / 2);
    end

endmodule

// File: rtl/adc_serial_fmt.sv
module adc_serial_fmt
    import fmt_pkg::*;
#(
    parameter int TPB = 12,
    localparam int TK_W = $clog2(TPB)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [9:0]  smp_i,
    input  logic [1:0]  wlen_i,
    input  logic        lsb_first_i,
    input  logic        invert_i,
    input  logic [2:0]  dphase_i,
    input  logic        test_word_i,
    output logic        ser_o,
    output logic        fclk_o,
    output logic        dclk_o
);

    cfg_t            cfg_in;
    cfg_t            cfg_q;
    logic [TK_W-1:0] tick_w;
    logic [BC_W-1:0] bitc_w;
    logic            fend_w;
    logic            shift_w;

    assign cfg_in = '{wlen: wlen_e'(wlen_i), lsb_first: lsb_first_i,
                      invert: invert_i, phase: dphase_i, test: test_word_i};

    fmt_timing #(.TPB(TPB)) u_timing (
        .clk       (clk),
        .rst       (rst),
        .wlen      (cfg_q.wlen),
        .tick      (tick_w),
        .bitc      (bitc_w),
        .frame_end (fend_w)
    );

    assign shift_w = (tick_w == TK_W'(TPB - 1));

    fmt_shreg u_shreg (
        .clk    (clk),
        .rst    (rst),
        .load   (fend_w),
        .shift  (shift_w),
        .smp    (smp_i),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .ser    (ser_o)
    );

    fmt_dclk #(.TPB(TPB)) u_dclk (
        .tick  (tick_w),
        .phase (cfg_q.phase),
        .dclk  (dclk_o)
    );

    assign fclk_o = (int'(bitc_w) < word_bits(cfg_q.wlen) / 2);

endmodule

// File: rtl/fmt_chk.sv
module fmt_chk
    import fmt_pkg::*;
#(
    parameter int TPB  = 12,
    localparam int TK_W = $clog2(TPB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TK_W-1:0]  tick,
    input  logic [BC_W-1:0]  bitc,
    input  logic             frame_end,
    input  cfg_t             cfg_q,
    input  logic             ser_o,
    input  logic             fclk_o,
    input  logic             dclk_o
);

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (!ser_o && !fclk_o && !dclk_o));

    a_r2_bit_held: assert property (@(posedge clk) disable iff (rst)
        (tick != TK_W'(TPB - 1)) |=> $stable(ser_o));

    a_r3_bit_index_in_word: assert property (@(posedge clk) disable iff (rst)
        int'(bitc) < word_bits(cfg_q.wlen));

    a_r8_frame_clock_at_start: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> fclk_o);

    a_r11_cfg_frozen_in_word: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(cfg_q));

endmodule

bind adc_serial_fmt fmt_chk #(.TPB(TPB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_w),
    .bitc      (bitc_w),
    .frame_end (fend_w),
    .cfg_q     (cfg_q),
    .ser_o     (ser_o),
    .fclk_o    (fclk_o),
    .dclk_o    (dclk_o)
);

// File: tb/adc_serial_fmt_test.sv
module adc_serial_fmt_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] smp_i = '0;
    logic [1:0] wlen_i = '0;
    logic       lsb_first_i = 1'b0;
    logic       invert_i = 1'b0;
    logic [2:0] dphase_i = '0;
    logic       test_word_i = 1'b0;
    logic       ser_o, fclk_o, dclk_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    adc_serial_fmt uut (
        .clk(clk), .rst(rst), .smp_i(smp_i), .wlen_i(wlen_i),
        .lsb_first_i(lsb_first_i), .invert_i(invert_i), .dphase_i(dphase_i),
        .test_word_i(test_word_i), .ser_o(ser_o), .fclk_o(fclk_o), .dclk_o(dclk_o)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int wbits(logic [1:0] w);
        case (w)
            2'b01:   return 8;
            2'b10:   return 12;
            2'b11:   return 14;
            default: return 10;
        endcase
    endfunction

    function automatic logic exp_ser(logic [9:0] s, logic [1:0] w, logic l,
                                     logic v, logic t, int j);
        logic [9:0] d;
        int         nd;
        logic       b;
        d  = t ? 10'b10_0000_0000 : s;
        nd = (w == 2'b01) ? 8 : 10;
        b  = 1'b0;
        if (j < nd) b = l ? d[10 - nd + j] : d[9 - j];
        return b ^ v;
    endfunction

    function automatic logic exp_dclk(logic [2:0] p, int t);
        int off;
        off = (3 + 2 * (int'(p) % 6)) % 12;
        return ((t - off + 12) % 12) < 6;
    endfunction

    // Called at the negedge where a word has just begun. Checks the whole word
    // against the inputs captured at that edge, after switching the inputs to
    // the next word's values (R11: those must not leak into this word).
    task automatic frame(logic [9:0] ns, logic [1:0] nw, logic nl,
                         logic nv, logic [2:0] np, logic nt);
        logic [9:0] cs = smp_i;
        logic [1:0] cw = wlen_i;
        logic       cl = lsb_first_i;
        logic       cv = invert_i;
        logic [2:0] cp = dphase_i;
        logic       ct = test_word_i;
        int         len = wbits(cw);
        string      tag;
        if (ct)              tag = "R10 test word";
        else if (cv)         tag = "R7 inversion";
        else if (cl)         tag = "R6 lsb first";
        else if (cw == 2'b01) tag = "R5 short word";
        else if (cw[1])      tag = "R4 zero padding";
        else                 tag = "R3 plain word";
        smp_i = ns; wlen_i = nw; lsb_first_i = nl;
        invert_i = nv; dphase_i = np; test_word_i = nt;
        for (int k = 0; k < len * 12; k++) begin
            chk({tag, " / R2 R11 ser_o"}, ser_o, exp_ser(cs, cw, cl, cv, ct, k / 12));
            chk("R8 fclk_o", fclk_o, (k / 12) < (len / 2));
            chk("R9 dclk_o", dclk_o, exp_dclk(cp, k % 12));
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd7341));
        smp_i = 10'b11_0100_1011;
        repeat (3) begin
            @(negedge clk);
            chk("R1 ser_o in reset", ser_o, 1'b0);
            chk("R1 fclk_o in reset", fclk_o, 1'b0);
            chk("R1 dclk_o in reset", dclk_o, 1'b0);
        end
        rst = 1'b0;
        @(negedge clk);
        // Directed corner cases: each call sets up the following word.
        frame(10'h2C5, 2'b10, 1'b0, 1'b0, 3'd1, 1'b0);   // runs 10-bit default
        frame(10'h1A7, 2'b11, 1'b0, 1'b0, 3'd2, 1'b0);   // runs 12-bit
        frame(10'h3F1, 2'b01, 1'b0, 1'b0, 3'd3, 1'b0);   // runs 14-bit
        frame(10'h0B3, 2'b00, 1'b1, 1'b0, 3'd4, 1'b0);   // runs 8-bit
        frame(10'h155, 2'b01, 1'b1, 1'b1, 3'd5, 1'b0);   // runs lsb first
        frame(10'h0F0, 2'b11, 1'b1, 1'b1, 3'd6, 1'b0);   // runs 8-bit lsb inverted
        frame(10'h3FF, 2'b00, 1'b0, 1'b0, 3'd7, 1'b1);   // runs 14-bit lsb inverted
        frame(10'h001, 2'b10, 1'b1, 1'b1, 3'd0, 1'b1);   // runs test word
        frame(10'h2AA, 2'b00, 1'b0, 1'b1, 3'd0, 1'b0);   // runs 12-bit test lsb inv
        for (int r = 0; r < 30; r++) begin
            frame(10'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                  3'($urandom), 1'(($urandom % 5) == 0));
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule